// File: doc/BRIEF.md
# Programmable Colour Space Converter

This block converts a stream of three-component 8-bit pixels from one colour space to another on the way from a pixel source to a display output. A small write-only register port holds a mode, a 3x3 matrix of signed fixed-point coefficients and three signed offsets. Software loads a coefficient set once. The pixel stream then flows through a two-stage pipeline with a valid/ready handshake on both sides.

Three conversions are available. Pass-through leaves pixels untouched. Luma/chroma-to-RGB adds each offset to its input component before the matrix, so software removes an input bias by programming a negative offset. RGB-to-luma/chroma adds the offsets to the matrix results on the output side. Every converted result is rounded half-up at the 8-bit fraction boundary and saturated to 0..255. Each pixel is converted with the configuration that was in force in the cycle it was accepted.

Top module: `colour_matrix_conv`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, all coefficients and offsets are zero and the mode is pass-through (code 0).
- R2: In mode 0 every output pixel equals its input pixel, component for component.
- R3: In mode 1 (luma/chroma to RGB), output channel i is the rounded and clamped value of the sum over k of M[i][k]*(in_k + D_k)/256. Component 0 is luma, taken as unsigned. Components 1 and 2 are chroma, biased by 128, and software removes that bias with D = -128.
- R4: In mode 2 (RGB to luma/chroma), output channel i is the rounded and clamped value of (the sum over k of M[i][k]*in_k + 256*D_i)/256.
- R5: A write to address 0 sets the mode from data bits [1:0]. Addresses 1 to 6 each hold two fields: the first in bits [10:0] and the second in bits [26:16]. The field order runs M00/M01, M02/M10, M11/M12, M20/M21, M22/D0, D1/D2. Matrix fields are 11-bit two's complement with 8 fractional bits, so 0x12A is about 1.164 and 0x79C is about -0.39.
- R6: Offsets are 9-bit two's complement integers in pixel units, for example 0x1F0 = -16 and 0x180 = -128. They are always added and never subtracted.
- R7: Rounding adds 128 to the sum, which carries 8 fractional bits, before truncation, so an exact half rounds up.
- R8: Converted results below 0 give 0 and results above 255 give 255.
- R9: A pixel accepted at a clock edge appears on the output port after the second edge, provided the output is not stalled.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output pixel holds steady. Backpressure stalls both stages, and no pixel is lost, duplicated or reordered.
- R11: A register write in the same cycle as a pixel acceptance does not affect that pixel. It applies from the next accepted pixel onward.
- R12: Mode code 3 behaves exactly as pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_c0 | input | 8 | Input component 0 (R or luma) |
| in_c1 | input | 8 | Input component 1 (G or blue-difference chroma) |
| in_c2 | input | 8 | Input component 2 (B or red-difference chroma) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_c0 | output | 8 | Output component 0 |
| out_c1 | output | 8 | Output component 1 |
| out_c2 | output | 8 | Output component 2 |

## Verification
A coefficient or offset captured in the wrong field shows up as a wrong colour on the very next converted pixel, two edges after acceptance. The reference vectors use two standard definition coefficient sets in both directions and were chosen to hit saturation at both ends and rounding on exact halves. A pipeline valid bit that is lost or stuck would drop, duplicate or stall a pixel. The bench's throttled stream exposes that within a few cycles through order and hold checks. Configuration that leaks into a pixel already in flight is caught by a mode change made in the same cycle as an acceptance.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    CSC_PASS     = 2'd0,
    CSC_YC2RGB   = 2'd1,
    CSC_RGB2YC   = 2'd2,
    CSC_PASS_ALT = 2'd3
  } csc_mode_e;

  localparam int NCH   = 3;
  localparam int NCOEF = NCH * NCH;
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HI_LSB = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output csc_mode_e                mode,
  output logic signed [COEF_W-1:0] coef [NCOEF],
  output logic signed [OFS_W-1:0]  ofs  [NCH]
);
  localparam int NFIELD = NCOEF + NCH;

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[DATA_W-1:HI_LSB+COEF_W], cfg_wdata[HI_LSB-1:COEF_W]};

  always_ff @(posedge clk) begin
    if (rst) mode <= CSC_PASS;
    else if (cfg_we && cfg_addr == '0) mode <= csc_mode_e'(cfg_wdata[1:0]);
  end

  p_mode_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == '0) |=> (mode == csc_mode_e'($past(cfg_wdata[1:0]))));

  // Two fields per word; word k+1 carries fields 2k (low) and 2k+1 (high).
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam int WORD = f / 2 + 1;
    localparam int LSB  = (f % 2 == 1) ? HI_LSB : 0;
    if (f < NCOEF) begin : g_coef
      always_ff @(posedge clk) begin
        if (rst) coef[f] <= '0;
        else if (cfg_we && cfg_addr == ADDR_W'(WORD)) coef[f] <= cfg_wdata[LSB +: COEF_W];
      end
      p_coef_write_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_W'(WORD)) |=> (coef[f] == $past(cfg_wdata[LSB +: COEF_W])));
    end else begin : g_ofs
      always_ff @(posedge clk) begin
        if (rst) ofs[f-NCOEF] <= '0;
        else if (cfg_we && cfg_addr == ADDR_W'(WORD)) ofs[f-NCOEF] <= cfg_wdata[LSB +: OFS_W];
      end
      p_ofs_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_W'(WORD)) |=> (ofs[f-NCOEF] == $past(cfg_wdata[LSB +: OFS_W])));
    end
  end
endmodule

// File: rtl/csc_mul_stage.sv
module csc_mul_stage
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int OPND_W = PIX_W + 2,
  parameter int PROD_W = COEF_W + OPND_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PIX_W-1:0]         in_pix   [NCH],
  input  csc_mode_e                mode,
  input  logic signed [COEF_W-1:0] coef     [NCOEF],
  input  logic signed [OFS_W-1:0]  ofs      [NCH],
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [PROD_W-1:0] out_prod [NCOEF],
  output logic [PIX_W-1:0]         out_pix  [NCH],
  output csc_mode_e                out_mode,
  output logic signed [OFS_W-1:0]  out_ofs  [NCH]
);
  logic signed [OPND_W-1:0] opnd [NCH];

  // Input-side offset only for luma/chroma to RGB.
  for (genvar k = 0; k < NCH; k++) begin : g_opnd
    logic signed [OPND_W-1:0] pix_s;
    logic signed [OPND_W-1:0] ofs_s;
    assign pix_s   = $signed({2'b00, in_pix[k]});
    assign ofs_s   = OPND_W'(ofs[k]);
    assign opnd[k] = (mode == CSC_YC2RGB) ? (pix_s + ofs_s) : pix_s;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_mode <= mode;
      for (int i = 0; i < NCH; i++) begin
        out_pix[i] <= in_pix[i];
        out_ofs[i] <= ofs[i];
        for (int k = 0; k < NCH; k++)
          out_prod[i*NCH+k] <= PROD_W'(coef[i*NCH+k]) * PROD_W'(opnd[k]);
      end
    end
  end

  p_stage_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mode) && $stable(out_pix[0])));
endmodule

// File: rtl/csc_sum_stage.sv
module csc_sum_stage
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int OFS_W  = 9,
  parameter int PROD_W = 21,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [PROD_W-1:0] in_prod [NCOEF],
  input  logic [PIX_W-1:0]         in_pix  [NCH],
  input  csc_mode_e                in_mode,
  input  logic signed [OFS_W-1:0]  in_ofs  [NCH],
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [PIX_W-1:0]         out_pix [NCH]
);
  localparam int ACC_W = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] ROUND   = ACC_W'(2 ** (FRAC - 1));
  localparam logic signed [ACC_W-1:0] ZERO_S  = '0;
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'(2 ** PIX_W - 1);

  logic convert;
  assign convert  = (in_mode == CSC_YC2RGB) || (in_mode == CSC_RGB2YC);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [ACC_W-1:0] bias, acc, shifted;
    logic [PIX_W-1:0]        res;

    // Output-side offset only for RGB to luma/chroma.
    assign bias = (in_mode == CSC_RGB2YC) ? (ACC_W'(in_ofs[c]) <<< FRAC) : ZERO_S;
    assign acc  = ACC_W'(in_prod[c*NCH]) + ACC_W'(in_prod[c*NCH+1])
                + ACC_W'(in_prod[c*NCH+2]) + bias + ROUND;
    assign shifted = acc >>> FRAC;

    always_comb begin
      if (!convert)              res = in_pix[c];
      else if (shifted < ZERO_S) res = '0;
      else if (shifted > PIX_MAX) res = '1;
      else                       res = shifted[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) out_pix[c] <= res;
    end

    p_bypass_copy_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && !convert) |=> (out_pix[c] == $past(in_pix[c])));
  end

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix[0]) &&
                                   $stable(out_pix[1]) && $stable(out_pix[2])));
endmodule

// File: rtl/colour_matrix_conv.sv
module colour_matrix_conv
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HI_LSB = 16,
  parameter int FRAC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_c0,
  input  logic [PIX_W-1:0]  in_c1,
  input  logic [PIX_W-1:0]  in_c2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_c0,
  output logic [PIX_W-1:0]  out_c1,
  output logic [PIX_W-1:0]  out_c2
);
  localparam int OPND_W = PIX_W + 2;
  localparam int PROD_W = COEF_W + OPND_W;

  csc_mode_e                mode, s1_mode;
  logic signed [COEF_W-1:0] coef    [NCOEF];
  logic signed [OFS_W-1:0]  ofs     [NCH];
  logic signed [OFS_W-1:0]  s1_ofs  [NCH];
  logic signed [PROD_W-1:0] s1_prod [NCOEF];
  logic [PIX_W-1:0]         in_pix  [NCH];
  logic [PIX_W-1:0]         s1_pix  [NCH];
  logic [PIX_W-1:0]         out_pix [NCH];
  logic                     s1_valid, s2_ready;

  assign in_pix[0] = in_c0;
  assign in_pix[1] = in_c1;
  assign in_pix[2] = in_c2;
  assign out_c0 = out_pix[0];
  assign out_c1 = out_pix[1];
  assign out_c2 = out_pix[2];

  csc_cfg_regs #(
    .COEF_W(COEF_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode(mode), .coef(coef), .ofs(ofs)
  );

  csc_mul_stage #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .OPND_W(OPND_W), .PROD_W(PROD_W)
  ) u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .mode(mode), .coef(coef), .ofs(ofs), .out_valid(s1_valid), .out_ready(s2_ready),
    .out_prod(s1_prod), .out_pix(s1_pix), .out_mode(s1_mode), .out_ofs(s1_ofs)
  );

  csc_sum_stage #(
    .PIX_W(PIX_W), .OFS_W(OFS_W), .PROD_W(PROD_W), .FRAC(FRAC)
  ) u_sum (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_ready(s2_ready), .in_prod(s1_prod),
    .in_pix(s1_pix), .in_mode(s1_mode), .in_ofs(s1_ofs), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  p_full_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/colour_matrix_conv_bench.sv
`timescale 1ns/1ps
module colour_matrix_conv_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_c0, out_c1, out_c2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  colour_matrix_conv u_colour_matrix_conv (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_ready(out_ready), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  // Coefficient sets: 0 limited-range luma/chroma->RGB, 1 full-range, 2 limited RGB->luma/chroma
  localparam logic [31:0] SETW [3][6] = '{
    '{32'h0000_012a, 32'h012a_0199, 32'h0730_079c, 32'h0204_012a, 32'h01f0_0000, 32'h0180_0180},
    '{32'h0000_0100, 32'h0100_0167, 32'h0749_07a8, 32'h01c6_0100, 32'h0000_0000, 32'h0180_0180},
    '{32'h0081_0041, 32'h07db_0019, 32'h0070_07b6, 32'h07a2_0070, 32'h0010_07ee, 32'h0080_0080}
  };
  localparam logic [31:0] SETMODE [3] = '{32'd1, 32'd1, 32'd2};

  // {set, in0, in1, in2, exp0, exp1, exp2}
  localparam int NVEC = 11;
  localparam logic [55:0] VEC [NVEC] = '{
    {8'd0,  8'd16, 8'd128, 8'd128,   8'd0,   8'd0,   8'd0},
    {8'd0, 8'd235, 8'd128, 8'd128, 8'd255, 8'd255, 8'd255},
    {8'd0, 8'd128, 8'd128, 8'd128, 8'd130, 8'd130, 8'd130},
    {8'd0,  8'd16, 8'd128, 8'd255, 8'd203,   8'd0,   8'd0},
    {8'd0,  8'd16,   8'd0, 8'd128,   8'd0,  8'd50,   8'd0},
    {8'd0, 8'd235, 8'd255, 8'd255, 8'd255, 8'd102, 8'd255},
    {8'd1, 8'd100, 8'd128, 8'd128, 8'd100, 8'd100, 8'd100},
    {8'd1,   8'd0, 8'd255,   8'd0,   8'd0,  8'd48, 8'd225},
    {8'd2,   8'd0,   8'd0,   8'd0,  8'd16, 8'd128, 8'd128},
    {8'd2, 8'd255, 8'd255, 8'd255, 8'd234, 8'd129, 8'd128},
    {8'd2, 8'd255,   8'd0,   8'd0,  8'd81,  8'd91, 8'd240}
  };

  task automatic check3(input string req, input logic [7:0] a0, a1, a2, e0, e1, e2);
    n_chk++;
    if (a0 !== e0 || a1 !== e1 || a2 !== e2) begin
      n_fail++;
      $display("FAIL %s: got %0d,%0d,%0d expected %0d,%0d,%0d", req, a0, a1, a2, e0, e1, e2);
    end
  endtask

  task automatic check1(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_set(input int s);
    for (int w = 0; w < 6; w++) wr(3'(w + 1), SETW[s][w]);
    wr(3'd0, SETMODE[s]);
  endtask

  // Send one pixel, wait for it; lat counts falling edges after the accepting edge.
  task automatic xfer(input logic [7:0] a, b, c, output logic [7:0] r0, r1, r2, output int lat);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_c0 = a; in_c1 = b; in_c2 = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r0 = out_c0; r1 = out_c1; r2 = out_c2;
  endtask

  function automatic logic [7:0] pv(input int i, input int c);
    return 8'((i * 37 + c * 91 + 5) % 256);
  endfunction

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r0, r1, r2;
    int lat;
    int cur;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check1("R1 out_valid after reset", int'(out_valid), 0);
    check1("R1 in_ready after reset", int'(in_ready), 1);
    // R1, R2: reset mode is pass-through
    xfer(8'd1, 8'd2, 8'd3, r0, r1, r2, lat);
    check3("R1 R2 reset mode bypass", r0, r1, r2, 8'd1, 8'd2, 8'd3);
    // R9: two-edge latency
    check1("R9 latency", lat, 2);

    // R3 R4 R5 R6 R8: table walk
    cur = -1;
    for (int i = 0; i < NVEC; i++) begin
      int s;
      s = int'(VEC[i][55:48]);
      if (s != cur) begin
        load_set(s);
        cur = s;
      end
      xfer(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], r0, r1, r2, lat);
      check3((s == 2) ? "R4 R5 R6 R8 vector" : "R3 R5 R6 R8 vector",
             r0, r1, r2, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R7: half-up rounding; M00 = 0.5, all else zero, mode 2
    wr(3'd1, 32'h0000_0080);
    for (int w = 2; w <= 6; w++) wr(3'(w), 32'h0);
    wr(3'd0, 32'd2);
    xfer(8'd1, 8'd0, 8'd0, r0, r1, r2, lat);
    check3("R7 half of 1 rounds up", r0, r1, r2, 8'd1, 8'd0, 8'd0);
    xfer(8'd3, 8'd0, 8'd0, r0, r1, r2, lat);
    check3("R7 1.5 rounds to 2", r0, r1, r2, 8'd2, 8'd0, 8'd0);
    xfer(8'd2, 8'd0, 8'd0, r0, r1, r2, lat);
    check3("R7 exact 1", r0, r1, r2, 8'd1, 8'd0, 8'd0);

    // R12: mode 3 passes through
    wr(3'd0, 32'd3);
    xfer(8'd200, 8'd17, 8'd3, r0, r1, r2, lat);
    check3("R12 mode 3 bypass", r0, r1, r2, 8'd200, 8'd17, 8'd3);

    // R11: mode write in the acceptance cycle applies to the next pixel
    load_set(0);
    wr(3'd0, 32'd0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'd1;
    in_valid = 1'b1; in_c0 = 8'd16; in_c1 = 8'd128; in_c2 = 8'd255;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check3("R11 same-cycle write ignored", out_c0, out_c1, out_c2, 8'd16, 8'd128, 8'd255);
    xfer(8'd16, 8'd128, 8'd255, r0, r1, r2, lat);
    check3("R11 write applies to next pixel", r0, r1, r2, 8'd203, 8'd0, 8'd0);

    // R10: throttled stream in pass-through
    wr(3'd0, 32'd0);
    begin
      int tx, rx;
      bit stall;
      logic [7:0] h0, h1, h2;
      tx = 0; rx = 0; stall = 1'b0; h0 = '0; h1 = '0; h2 = '0;
      for (int cyc = 0; cyc < 400 && rx < 8; cyc++) begin
        @(negedge clk);
        if (stall) begin
          check1("R10 valid held under stall", int'(out_valid), 1);
          check3("R10 data held under stall", out_c0, out_c1, out_c2, h0, h1, h2);
        end
        out_ready = (cyc % 3) != 2;
        in_valid = (tx < 8);
        in_c0 = pv(tx, 0); in_c1 = pv(tx, 1); in_c2 = pv(tx, 2);
        #1;
        stall = out_valid && !out_ready;
        h0 = out_c0; h1 = out_c1; h2 = out_c2;
        if (out_valid && out_ready) begin
          check3("R10 stream order", out_c0, out_c1, out_c2, pv(rx, 0), pv(rx, 1), pv(rx, 2));
          rx++;
        end
        if (in_valid && in_ready) tx++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      check1("R10 all pixels delivered", rx, 8);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule